// File: doc/BRIEF.md
# Watchdog Timer with Sticky Overflow Flag

This block is a supervisory counter driven by a slow periodic tick. Software must prove it is alive by touching the block's reset-status register at least once per chosen timeout. Any access to that register, read or write, restarts the count. If the count runs out first, the block drives a one-cycle system reset pulse. It also sets an overflow flag that the rest of the system can read back after the reset to learn why the reset happened.

A static enable input stands in for a configuration option that is fixed at power-up; software has no way to change it. A power-down input tells the block that the system is asleep. The watchdog keeps counting while asleep. An expiry in that state also raises a wake indication alongside the reset pulse. A 3-bit select chooses one of eight timeouts, spanning 1 ms to about 4 s at a 1 kHz tick.

The register access port is plain control: one strobe, a write qualifier and a single data bit. The flag is presented on a read-data output at all times, so there is no data stream and no back-pressure.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset (`rst_n` low), `wdt_rst`, `pd_wake` and `ovf_flag` are all 0.
- R2: With `wdt_en` high, a timeout expires on the Nth tick after a restart, counting `tick` cycles only. N is set by `tmo_sel` (× `TICKS_PER_MS`): 0→1, 1→4, 2→16, 3→64, 4→256, 5→512, 6→1024, 7→4096. `wdt_rst` is high in the cycle after the clock edge that takes that tick.
- R3: `wdt_rst` lasts one cycle when ticks are sparse. Counting restarts from zero, so with no service the next pulse comes a full period later.
- R4: A read access (`acc_en`=1, `acc_we`=0) restarts the count from zero.
- R5: A write access (`acc_en`=1, `acc_we`=1) restarts the count from zero, whatever the value of `acc_wdata`.
- R6: Each expiry sets `ovf_flag` in the same cycle that `wdt_rst` rises. The flag stays set through reads, through writes with `acc_wdata`=1 and through further expiries.
- R7: `ovf_flag` is cleared only by a write with `acc_wdata`=0 or by `rst_n`.
- R8: With `wdt_en` low, the count is held at zero and `wdt_rst` never rises. After enabling, a full period is needed.
- R9: `pd_mode` does not stop counting. An expiry taken while `pd_mode` is high also raises `pd_wake` for that same cycle. `pd_wake` is never high without `wdt_rst`.
- R10: Clock cycles without `tick` do not advance the count. With a tick on every other cycle, expiry happens 2N-1 cycles after the first tick.
- R11: An access in the same cycle as a tick wins: the count restarts and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_en | input | 1 | Static enable from the power-up configuration |
| tick | input | 1 | One-cycle pulse of the slow time base |
| tmo_sel | input | 3 | Timeout select |
| pd_mode | input | 1 | High while the system is in power-down |
| acc_en | input | 1 | Access strobe for the reset-status register |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_wdata | input | 1 | Write data for the overflow flag bit (0 clears) |
| ovf_flag | output | 1 | Read data: sticky watchdog overflow flag |
| wdt_rst | output | 1 | System reset pulse |
| pd_wake | output | 1 | Expiry occurred while in power-down |

## Verification
Every timeout select is run with a tick on every cycle. Power-down is set on alternate selects, which tells apart a correct period table from a shifted or mis-ordered one and shows that sleep does not stall counting. A sparse tick pattern separates counting ticks from counting clocks. Services are placed one tick before expiry, both alone and coinciding with a tick, and by read and by write, so that each restart path and the access-over-tick priority can be seen. Flag tests cover write-1, write-0, read, repeat expiry and power-on reset, which separates a sticky flag from one that clears on read or on any write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int SEL_W = 3;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int LONGEST_MS = 4096;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_CLEAR  = 2'd1,
    CNT_STEP   = 2'd2,
    CNT_EXPIRE = 2'd3
  } cnt_op_e;

  // Timeout in milliseconds for each select code.
  function automatic int unsigned period_ms(input int unsigned sel);
    int unsigned ms;
    if (sel < 5) ms = 1 << (2 * sel);
    else if (sel == 7) ms = LONGEST_MS;
    else ms = 1 << (sel + 4);
    return ms;
  endfunction

endpackage

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel #(
  parameter int TICKS_PER_MS = 1,
  parameter int CW = 13
) (
  input  logic [wdt_pkg::SEL_W-1:0] sel,
  output logic [CW-1:0]             last_cnt
);
  logic [CW-1:0] table_q [wdt_pkg::NUM_SEL];

  for (genvar g = 0; g < wdt_pkg::NUM_SEL; g++) begin : g_row
    localparam int unsigned TICKS = wdt_pkg::period_ms(g) * TICKS_PER_MS;
    assign table_q[g] = CW'(TICKS - 1);
  end

  assign last_cnt = table_q[sel];
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int CW = 13
) (
  input  logic            enable,
  input  logic            service,
  input  logic            tick,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   last_cnt,
  output wdt_pkg::cnt_op_e op
);
  always_comb begin
    if (!enable || service) op = wdt_pkg::CNT_CLEAR;
    else if (tick && (cnt >= last_cnt)) op = wdt_pkg::CNT_EXPIRE;
    else if (tick) op = wdt_pkg::CNT_STEP;
    else op = wdt_pkg::CNT_HOLD;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdt_pkg::cnt_op_e op,
  input  logic             pd_mode,
  output logic [CW-1:0]    cnt,
  output logic             rst_pulse,
  output logic             wake_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rst_pulse  <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      case (op)
        wdt_pkg::CNT_CLEAR:  cnt <= '0;
        wdt_pkg::CNT_EXPIRE: cnt <= '0;
        wdt_pkg::CNT_STEP:   cnt <= cnt + CW'(1);
        default:             cnt <= cnt;
      endcase
      rst_pulse  <= (op == wdt_pkg::CNT_EXPIRE);
      wake_pulse <= (op == wdt_pkg::CNT_EXPIRE) && pd_mode;
    end
  end
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int TICKS_PER_MS = 1,
  localparam int CW = $clog2(wdt_pkg::LONGEST_MS * TICKS_PER_MS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_en,
  input  logic       tick,
  input  logic [2:0] tmo_sel,
  input  logic       pd_mode,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic       acc_wdata,
  output logic       ovf_flag,
  output logic       wdt_rst,
  output logic       pd_wake
);
  logic [CW-1:0]    last_cnt;
  logic [CW-1:0]    cnt_q;
  wdt_pkg::cnt_op_e op;
  logic             expire;
  logic             clr_req;

  wdt_limit_sel #(.TICKS_PER_MS(TICKS_PER_MS), .CW(CW)) u_limit (
    .sel      (tmo_sel),
    .last_cnt (last_cnt)
  );

  wdt_ctrl #(.CW(CW)) u_ctrl (
    .enable   (wdt_en),
    .service  (acc_en),
    .tick     (tick),
    .cnt      (cnt_q),
    .last_cnt (last_cnt),
    .op       (op)
  );

  wdt_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .pd_mode    (pd_mode),
    .cnt        (cnt_q),
    .rst_pulse  (wdt_rst),
    .wake_pulse (pd_wake)
  );

  assign expire  = (op == wdt_pkg::CNT_EXPIRE);
  assign clr_req = acc_en && acc_we && !acc_wdata;

  wdt_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (expire),
    .clr_evt (clr_req),
    .flag    (ovf_flag)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wdt_en,
  input logic          acc_en,
  input logic          acc_we,
  input logic          acc_wdata,
  input logic          ovf_flag,
  input logic          wdt_rst,
  input logic          pd_wake,
  input logic [CW-1:0] cnt
);
  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (cnt == '0));
  // R6
  flag_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> ovf_flag);
  // R7
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(acc_en && acc_we && !acc_wdata));
  // R4
  service_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (cnt == '0));
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> ((cnt == '0) && !wdt_rst));
  // R11
  service_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> !wdt_rst);
  // R9
  wake_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_wake |-> wdt_rst);
endmodule

bind wdog_timer wdog_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wdt_en    (wdt_en),
  .acc_en    (acc_en),
  .acc_we    (acc_we),
  .acc_wdata (acc_wdata),
  .ovf_flag  (ovf_flag),
  .wdt_rst   (wdt_rst),
  .pd_wake   (pd_wake),
  .cnt       (cnt_q)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_en = 1'b1;
  logic tick = 1'b0;
  logic [2:0] tmo_sel = 3'd0;
  logic pd_mode = 1'b0;
  logic acc_en = 1'b0, acc_we = 1'b0, acc_wdata = 1'b0;
  logic ovf_flag, wdt_rst, pd_wake;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .tick(tick), .tmo_sel(tmo_sel),
    .pd_mode(pd_mode), .acc_en(acc_en), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .ovf_flag(ovf_flag), .wdt_rst(wdt_rst), .pd_wake(pd_wake)
  );

  // {pd_mode, tmo_sel, expected ticks}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 3'd0, 13'd1},    {1'b1, 3'd1, 13'd4},
    {1'b0, 3'd2, 13'd16},   {1'b1, 3'd3, 13'd64},
    {1'b0, 3'd4, 13'd256},  {1'b1, 3'd5, 13'd512},
    {1'b0, 3'd6, 13'd1024}, {1'b1, 3'd7, 13'd4096}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic access(input logic we, input logic wd, input logic tk);
    acc_en = 1'b1; acc_we = we; acc_wdata = wd; tick = tk;
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; acc_wdata = 1'b0; tick = 1'b0;
  endtask

  task automatic measure(input int every, output int n);
    n = 0;
    for (int i = 1; i <= 20000; i++) begin
      tick = ((i - 1) % every) == 0;
      @(posedge clk); @(negedge clk);
      tick = 1'b0;
      if (wdt_rst) begin n = i; break; end
    end
  endtask

  task automatic run_ticks(input int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      tick = 1'b0;
      if (wdt_rst) seen++;
    end
  endtask

  initial begin
    int n, seen;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 wdt_rst in reset", int'(wdt_rst), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ovf_flag after reset", int'(ovf_flag), 0);
    check("R1 pd_wake after reset", int'(pd_wake), 0);

    // R2 / R9 / R6 / R3 table walk
    foreach (VEC[v]) begin
      pd_mode = VEC[v][16];
      tmo_sel = VEC[v][15:13];
      access(1'b0, 1'b0, 1'b0);
      measure(1, n);
      check($sformatf("R2 period sel=%0d", tmo_sel), n, int'(VEC[v][12:0]));
      check("R6 flag set on expiry", int'(ovf_flag), 1);
      check("R9 pd_wake follows pd_mode", int'(pd_wake), int'(VEC[v][16]));
      @(negedge clk);
      check("R3 pulse single cycle", int'(wdt_rst), 0);
      access(1'b1, 1'b0, 1'b0);
      check("R7 write 0 clears flag", int'(ovf_flag), 0);
    end
    pd_mode = 1'b0;

    // R3 back-to-back periods without service
    tmo_sel = 3'd1;
    access(1'b0, 1'b0, 1'b0);
    measure(1, n);
    check("R3 first period", n, 4);
    measure(1, n);
    check("R3 second period restarts from zero", n, 4);

    // R10 sparse ticks
    tmo_sel = 3'd2;
    access(1'b0, 1'b0, 1'b0);
    measure(2, n);
    check("R10 every-other tick", n, 31);

    // R6 flag survives read, write-1 and repeat expiry (flag is 1 here)
    access(1'b0, 1'b0, 1'b0);
    check("R6 read keeps flag", int'(ovf_flag), 1);
    access(1'b1, 1'b1, 1'b0);
    check("R6 write 1 keeps flag", int'(ovf_flag), 1);

    // R4 read restarts one tick before expiry
    tmo_sel = 3'd1;
    access(1'b0, 1'b0, 1'b0);
    run_ticks(3, seen);
    access(1'b0, 1'b0, 1'b0);
    check("R4 no pulse before read", seen, 0);
    measure(1, n);
    check("R4 full period after read", n, 4);

    // R5 write of 1 restarts
    run_ticks(3, seen);
    access(1'b1, 1'b1, 1'b0);
    measure(1, n);
    check("R5 full period after write", n, 4);
    check("R6 flag still set after repeat expiry", int'(ovf_flag), 1);

    // R11 access and tick together
    run_ticks(3, seen);
    access(1'b0, 1'b0, 1'b1);
    check("R11 no pulse on contested cycle", int'(wdt_rst), 0);
    measure(1, n);
    check("R11 tick lost, full period", n, 4);

    // R7 clear by write 0, then power-on reset clears
    access(1'b1, 1'b0, 1'b0);
    check("R7 write 0 clears", int'(ovf_flag), 0);
    measure(1, n);
    check("R7 flag set again", int'(ovf_flag), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 power-on reset clears flag", int'(ovf_flag), 0);

    // R8 disabled: no counting, no pulse
    wdt_en = 1'b0;
    tmo_sel = 3'd1;
    run_ticks(50, seen);
    check("R8 no pulse while disabled", seen, 0);
    check("R8 flag untouched while disabled", int'(ovf_flag), 0);
    wdt_en = 1'b1;
    measure(1, n);
    check("R8 full period after enable", n, 4);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule